// File: doc/BRIEF.md
# Trace timestamp and sync packetizer

This block is a packet source for an instrumentation trace path. It keeps a free-running timestamp counter and turns three kinds of event into byte packets for a downstream trace formatter. An external periodic trigger yields a six-byte synchronization packet. A stimulus write that arrives while the stimulus FIFO is full is dropped and yields a one-byte overflow marker. A stimulus write that is accepted yields a local-timestamp packet carrying the counter value, and the counter then starts again from zero.

Packets leave one byte per handshake on a valid/ready byte port. When more than one packet is waiting, they are ordered by a fixed priority, and a packet that has begun is never broken up. Software reaches a control register through a small write/read port. Writes to that register take effect only after a 32-bit key has been written to a separate lock register. The counter advances once per prescaled tick. The tick comes either from the core clock or from a single-cycle enable pulse that marks the serial-trace clock and is already in this clock domain.

Top module: `trc_stamp_top`

## Requirements
- R1: After reset the control register reads 0, the lock is closed, `pkt_valid` is 0 and the busy flag (control bit 23) is 0.
- R2: A write to the control register (`reg_sel`=0) changes nothing while the lock is closed. Writing 0xC5ACCE55 to the lock register (`reg_sel`=1) opens the lock, and writing any other value to it closes the lock again.
- R3: The control register reads back global enable at bit 0, timestamp enable at bit 1, sync enable at bit 2, stimulus enable at bit 3, tick select at bit 4, prescaler code at bits 9:8, source ID at bits 22:16 and busy at bit 23. All other bits read 0.
- R4: Each `sync_trig` pulse with global enable and sync enable both set produces the bytes 00 00 00 00 00 80 in that order. A pulse with either enable clear produces nothing.
- R5: A stimulus write with `fifo_full`=1 produces the single byte 0x70 and no timestamp packet.
- R6: A stimulus write with `fifo_full`=0 and timestamp enable set produces a header byte 0xC0, then the counter value in 7-bit groups, least significant group first. Each group byte has bit 7 set except the last one. The packet uses the fewest groups that hold the value, and always at least one.
- R7: The counter is 21 bits wide and saturates at its maximum. It advances once every 1, 4, 16 or 64 ticks for prescaler codes 0, 1, 2 and 3. It restarts from zero, prescaler phase included, in the cycle a timestamp packet begins.
- R8: With tick select 0 the counter ticks on every clock. With tick select 1 it ticks only in cycles where `trace_tick` is 1.
- R9: Stimulus writes cause no packet unless global enable and stimulus enable are both set.
- R10: Waiting packets start in the order sync, then overflow, then timestamp. While `pkt_valid` is high and `pkt_ready` is low, the byte on `pkt_data` stays unchanged, and no packet interrupts another.
- R11: The busy flag reads 1 while any packet is waiting or being sent, and 0 otherwise.
- R12: Clearing global enable discards every waiting packet. The byte on the port still completes its handshake, and after that `pkt_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_sel | input | 1 | Register select: 0 control, 1 lock |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (lock reads 0) |
| trace_tick | input | 1 | Serial-trace clock enable pulse, already synchronous |
| sync_trig | input | 1 | Periodic synchronization trigger pulse |
| stim_wr | input | 1 | Stimulus write strobe |
| fifo_full | input | 1 | Stimulus FIFO full at the time of the write |
| pkt_data | output | 8 | Packet byte |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_ready | input | 1 | Downstream accepts the byte |

## Verification
The embedded properties check on every cycle that a locked control write leaves the fields unchanged, that a stalled byte holds steady, that nothing is presented after a disable-time handshake, that every timestamp start is followed by the 0xC0 header, and that the counter never steps backwards between restarts. Only the bench scenarios can show the things that depend on history. These are the exact counter value in each timestamp packet under every prescaler code and both tick sources, the minimal group count at the 1-, 2- and 3-group boundaries, the arbitration order of a backlog released at once, and the silence produced by disabled triggers and stimulus writes.

// File: rtl/trc_stamp_pkg.sv
package trc_stamp_pkg;

   typedef enum logic [1:0] {
      PK_NONE = 2'd0,
      PK_SYNC = 2'd1,
      PK_OVF  = 2'd2,
      PK_TS   = 2'd3
   } pkt_kind_e;

   typedef struct packed {
      logic       clk_sel;
      logic [1:0] presc;
      logic       stim_en;
      logic       sync_en;
      logic       ts_en;
      logic       glb_en;
   } ctrl_t;

   localparam logic [7:0] TS_HDR_BYTE  = 8'hC0;
   localparam logic [7:0] OVF_BYTE     = 8'h70;
   localparam logic [7:0] SYNC_TAIL    = 8'h80;
   localparam int unsigned SYNC_BYTES  = 6;
   localparam int unsigned GRP_BITS    = 7;

   // Fewest 7-bit groups that hold v (never less than one).
   function automatic int unsigned grp_need(input logic [31:0] v, input int unsigned ngrp);
      int unsigned n;
      n = 1;
      for (int unsigned g = 1; g < 5; g++) begin
         if (g < ngrp && (v >> (GRP_BITS * g)) != 32'd0) n = g + 1;
      end
      return n;
   endfunction

endpackage

// File: rtl/trc_stamp_regs.sv
module trc_stamp_regs
   import trc_stamp_pkg::*;
#(
   parameter int unsigned ID_W    = 7,
   parameter logic [31:0] LOCK_KEY = 32'hC5AC_CE55
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_sel,
   input  logic            reg_we,
   input  logic [31:0]     reg_wdata,
   input  logic            busy,
   output logic [31:0]     reg_rdata,
   output ctrl_t           ctrl
);

   if (ID_W < 1 || ID_W > 7) begin : g_bad_id
      $error("trc_stamp_regs: ID_W must be 1..7");
   end

   logic            unlocked;
   logic [ID_W-1:0] src_id;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         ctrl     <= '0;
         src_id   <= '0;
      end else if (reg_we) begin
         if (reg_sel) begin
            unlocked <= (reg_wdata == LOCK_KEY);
         end else if (unlocked) begin
            ctrl.glb_en  <= reg_wdata[0];
            ctrl.ts_en   <= reg_wdata[1];
            ctrl.sync_en <= reg_wdata[2];
            ctrl.stim_en <= reg_wdata[3];
            ctrl.clk_sel <= reg_wdata[4];
            ctrl.presc   <= reg_wdata[9:8];
            src_id       <= reg_wdata[16 +: ID_W];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (!reg_sel) begin
         reg_rdata[0]         = ctrl.glb_en;
         reg_rdata[1]         = ctrl.ts_en;
         reg_rdata[2]         = ctrl.sync_en;
         reg_rdata[3]         = ctrl.stim_en;
         reg_rdata[4]         = ctrl.clk_sel;
         reg_rdata[9:8]       = ctrl.presc;
         reg_rdata[16 +: ID_W] = src_id;
         reg_rdata[23]        = busy;
      end
   end

   // R2: while locked a control write leaves every field untouched
   assert_locked_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && reg_we && !reg_sel) |=> ($stable(ctrl) && $stable(src_id)));

endmodule

// File: rtl/trc_stamp_ctr.sv
module trc_stamp_ctr #(
   parameter int unsigned TS_W        = 21,
   parameter int unsigned PRESC_SHIFT = 2,
   parameter bit          SATURATE    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            sel_trace,
   input  logic            trace_tick,
   input  logic [1:0]      presc,
   input  logic            restart,
   output logic [TS_W-1:0] cnt
);

   localparam int unsigned PW = 3 * PRESC_SHIFT;

   if (PRESC_SHIFT < 1 || PRESC_SHIFT > 4) begin : g_bad_shift
      $error("trc_stamp_ctr: PRESC_SHIFT must be 1..4");
   end

   logic [PW-1:0]   pre;
   logic [PW-1:0]   lim;
   logic            tick;
   logic [TS_W-1:0] cnt_next;

   assign tick = sel_trace ? trace_tick : 1'b1;

   always_comb begin
      lim = PW'((32'd1 << (PRESC_SHIFT * int'(presc))) - 32'd1);
   end

   if (SATURATE) begin : g_sat
      assign cnt_next = (&cnt) ? cnt : cnt + 1'b1;
   end else begin : g_wrap
      assign cnt_next = cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) begin
         pre <= '0;
         cnt <= '0;
      end else if (tick) begin
         if (pre >= lim) begin
            pre <= '0;
            cnt <= cnt_next;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

   // R7: between restarts the count never steps backwards
   if (SATURATE) begin : g_mono
      assert_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !restart) |=> (cnt >= $past(cnt)));
   end

endmodule

// File: rtl/trc_stamp_seq.sv
module trc_stamp_seq
   import trc_stamp_pkg::*;
#(
   parameter int unsigned TS_W = 21
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            sync_req,
   input  logic            ovf_req,
   input  logic            ts_req,
   input  logic [TS_W-1:0] cnt,
   input  logic            pkt_ready,
   output logic [7:0]      pkt_data,
   output logic            pkt_valid,
   output logic            ts_restart,
   output logic            busy
);

   localparam int unsigned NGRP  = (TS_W + GRP_BITS - 1) / GRP_BITS;
   localparam int unsigned MAXI  = (NGRP > SYNC_BYTES - 1) ? NGRP : SYNC_BYTES - 1;
   localparam int unsigned IDX_W = $clog2(MAXI + 1);
   localparam int unsigned CAP_W = GRP_BITS * NGRP;

   if (TS_W < 8 || TS_W > 28) begin : g_bad_ts
      $error("trc_stamp_seq: TS_W must be 8..28");
   end

   logic             pend_sync, pend_ovf, pend_ts;
   logic             sending;
   pkt_kind_e        kind, pick;
   logic [IDX_W-1:0] idx, last_idx;
   logic [CAP_W-1:0] cap;
   logic             start, fire;
   logic [CAP_W-1:0] grp_sh;

   assign start = !sending && en && (pend_sync || pend_ovf || pend_ts);
   assign fire  = pkt_valid && pkt_ready;

   always_comb begin
      if (pend_sync)     pick = PK_SYNC;
      else if (pend_ovf) pick = PK_OVF;
      else if (pend_ts)  pick = PK_TS;
      else               pick = PK_NONE;
   end

   assign ts_restart = start && (pick == PK_TS);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         pend_sync <= 1'b0;
         pend_ovf  <= 1'b0;
         pend_ts   <= 1'b0;
      end else begin
         pend_sync <= (pend_sync && !(start && pick == PK_SYNC)) || sync_req;
         pend_ovf  <= (pend_ovf  && !(start && pick == PK_OVF))  || ovf_req;
         pend_ts   <= (pend_ts   && !(start && pick == PK_TS))   || ts_req;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sending  <= 1'b0;
         kind     <= PK_NONE;
         idx      <= '0;
         last_idx <= '0;
         cap      <= '0;
      end else if (start) begin
         sending <= 1'b1;
         kind    <= pick;
         idx     <= '0;
         case (pick)
            PK_SYNC: last_idx <= IDX_W'(SYNC_BYTES - 1);
            PK_TS:   last_idx <= IDX_W'(grp_need(32'(cnt), NGRP));
            default: last_idx <= '0;
         endcase
         cap <= CAP_W'(cnt);
      end else if (fire) begin
         if (idx == last_idx || !en) begin
            sending <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign grp_sh = cap >> (GRP_BITS * (int'(idx) - 1));

   always_comb begin
      case (kind)
         PK_SYNC: pkt_data = (idx == last_idx) ? SYNC_TAIL : 8'h00;
         PK_OVF:  pkt_data = OVF_BYTE;
         PK_TS:   pkt_data = (idx == '0) ? TS_HDR_BYTE : {idx != last_idx, grp_sh[6:0]};
         default: pkt_data = 8'h00;
      endcase
   end

   assign pkt_valid = sending;
   assign busy      = sending || pend_sync || pend_ovf || pend_ts;

   // R10: a stalled byte stays on the port unchanged
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

   // R12: with global enable clear, a completed handshake ends the stream
   assert_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && fire) |=> !pkt_valid);

   // R6: every timestamp start presents the header byte next
   assert_ts_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ts_restart |=> (pkt_valid && pkt_data == TS_HDR_BYTE));

endmodule

// File: rtl/trc_stamp_top.sv
module trc_stamp_top
   import trc_stamp_pkg::*;
#(
   parameter int unsigned TS_W        = 21,
   parameter int unsigned ID_W        = 7,
   parameter int unsigned PRESC_SHIFT = 2,
   parameter bit          SATURATE    = 1'b1,
   parameter logic [31:0] LOCK_KEY    = 32'hC5AC_CE55
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_sel,
   input  logic        reg_we,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        trace_tick,
   input  logic        sync_trig,
   input  logic        stim_wr,
   input  logic        fifo_full,
   output logic [7:0]  pkt_data,
   output logic        pkt_valid,
   input  logic        pkt_ready
);

   ctrl_t           ctrl;
   logic            busy;
   logic            ts_restart;
   logic [TS_W-1:0] cnt;
   logic            stim_ok, sync_req, ovf_req, ts_req;

   assign stim_ok  = stim_wr && ctrl.glb_en && ctrl.stim_en;
   assign sync_req = sync_trig && ctrl.glb_en && ctrl.sync_en;
   assign ovf_req  = stim_ok && fifo_full;
   assign ts_req   = stim_ok && !fifo_full && ctrl.ts_en;

   trc_stamp_regs #(.ID_W(ID_W), .LOCK_KEY(LOCK_KEY)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .busy      (busy),
      .reg_rdata (reg_rdata),
      .ctrl      (ctrl)
   );

   trc_stamp_ctr #(.TS_W(TS_W), .PRESC_SHIFT(PRESC_SHIFT), .SATURATE(SATURATE)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (ctrl.glb_en && ctrl.ts_en),
      .sel_trace  (ctrl.clk_sel),
      .trace_tick (trace_tick),
      .presc      (ctrl.presc),
      .restart    (ts_restart),
      .cnt        (cnt)
   );

   trc_stamp_seq #(.TS_W(TS_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl.glb_en),
      .sync_req   (sync_req),
      .ovf_req    (ovf_req),
      .ts_req     (ts_req),
      .cnt        (cnt),
      .pkt_ready  (pkt_ready),
      .pkt_data   (pkt_data),
      .pkt_valid  (pkt_valid),
      .ts_restart (ts_restart),
      .busy       (busy)
   );

   // R4: a trigger with sync disabled never leaves the port idle-to-busy on its own
   assert_sync_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_trig && !ctrl.sync_en && !stim_wr && !busy) |=> !busy);

endmodule

// File: tb/trc_stamp_top_bench.sv
module trc_stamp_top_bench;

   localparam logic [31:0] KEY = 32'hC5AC_CE55;
   localparam int unsigned TSMAX = (1 << 21) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        trace_tick = 1'b0, sync_trig = 1'b0, stim_wr = 1'b0, fifo_full = 1'b0;
   logic [7:0]  pkt_data;
   logic        pkt_valid;
   logic        pkt_ready = 1'b0;

   always #2 clk = ~clk;

   trc_stamp_top u_trc_stamp_top (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trace_tick(trace_tick),
      .sync_trig(sync_trig), .stim_wr(stim_wr), .fifo_full(fifo_full),
      .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // ---------------- stream monitor (samples at negedge) ----------------
   int     tb_sel = 0, tb_div = 1;
   bit     have_prev = 0;
   longint acc = 0, prev_acc = 0;
   int     last_tick = 0;
   bit     held = 0;
   bit     exp_ok = 0;
   longint exp_val = 0;
   int     pst = 0, pcnt = 0;
   longint pval = 0;
   int     n_bytes = 0, n_sync = 0, n_ovf = 0, n_ts = 0, n_g2 = 0, n_g3 = 0;
   int     log_k [0:15];
   int     n_log = 0;

   function automatic longint ts_expect(input longint ticks, input int div);
      longint v;
      v = ticks / div;
      return (v > TSMAX) ? TSMAX : v;
   endfunction

   task automatic log_pkt(input int k);
      if (n_log < 16) log_k[n_log] = k;
      n_log++;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         int t;
         if (pkt_valid && !held && pst == 0 && pkt_data == 8'hC0) begin
            exp_ok  = have_prev;
            exp_val = ts_expect(acc - last_tick - prev_acc, tb_div);
            prev_acc = acc;
            have_prev = 1;
         end
         t = (tb_sel != 0) ? int'(trace_tick) : 1;
         acc += t;
         last_tick = t;
         held = pkt_valid && !pkt_ready;
         if (pkt_valid && pkt_ready) begin
            logic [7:0] b;
            b = pkt_data;
            n_bytes++;
            case (pst)
               0: begin
                  if (b == 8'h00) begin pst = 1; pcnt = 1; end
                  else if (b == 8'h70) begin n_ovf++; log_pkt(2); end
                  else if (b == 8'hC0) begin pst = 2; pcnt = 0; pval = 0; end
                  else chk(0, "R10 packet start byte", b, 8'hC0);
               end
               1: begin
                  if (pcnt < 5) begin
                     chk(b == 8'h00, "R4 sync body byte", b, 8'h00);
                     pcnt++;
                  end else begin
                     chk(b == 8'h80, "R4 sync last byte", b, 8'h80);
                     n_sync++; log_pkt(1); pst = 0;
                  end
               end
               default: begin
                  pval |= longint'(b[6:0]) << (7 * pcnt);
                  pcnt++;
                  if (!b[7]) begin
                     chk(pcnt == 1 || b[6:0] != 0, "R6 minimal group count", pcnt, pcnt - 1);
                     if (pcnt == 2) n_g2++;
                     if (pcnt == 3) n_g3++;
                     if (exp_ok) chk(pval == exp_val, "R7 timestamp value", pval, exp_val);
                     n_ts++; log_pkt(3); pst = 0;
                  end else if (pcnt >= 3) begin
                     chk(0, "R6 group count limit", pcnt + 1, 3);
                     pst = 0;
                  end
               end
            endcase
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] mk(input bit en, input bit ts, input bit sy, input bit st,
                                      input bit sel, input int pr, input int id);
      return {8'h00, 1'b0, 7'(id), 6'h00, 2'(pr), 3'b000, sel, st, sy, ts, en};
   endfunction

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
      step(1);
      reg_we = 1'b0; reg_sel = 1'b0;
   endtask

   task automatic cfg(input logic [31:0] d);
      wr(1'b0, d);
      tb_sel = int'(d[4]);
      tb_div = 1 << (2 * int'(d[9:8]));
      have_prev = 0;
   endtask

   task automatic pulse_stim(input bit full);
      stim_wr = 1'b1; fifo_full = full;
      step(1);
      stim_wr = 1'b0; fifo_full = 1'b0;
   endtask

   task automatic pulse_sync();
      sync_trig = 1'b1;
      step(1);
      sync_trig = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 190000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      int b0;
      process::self().srandom(32'd1234);
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk(reg_rdata == 32'h0, "R1 control after reset", reg_rdata, 0);
      chk(pkt_valid == 1'b0, "R1 valid after reset", pkt_valid, 0);

      // R2 locked writes ignored
      wr(1'b0, mk(1, 1, 1, 1, 0, 0, 5));
      chk(reg_rdata == 32'h0, "R2 locked write ignored", reg_rdata, 0);
      wr(1'b1, KEY);
      wr(1'b0, 32'hFFFF_FFFF);
      // R3 layout: only defined fields, busy 0
      chk(reg_rdata == 32'h007F_031F, "R3 readback layout", reg_rdata, 32'h007F_031F);
      wr(1'b1, 32'h1234_5678);
      wr(1'b0, 32'h0);
      chk(reg_rdata == 32'h007F_031F, "R2 relock on wrong key", reg_rdata, 32'h007F_031F);
      wr(1'b1, KEY);
      wr(1'b0, 32'h0);
      chk(reg_rdata == 32'h0, "R2 unlocked write", reg_rdata, 0);
      step(2);
      chk(n_bytes == 0, "R12 nothing sent while disabled", n_bytes, 0);

      pkt_ready = 1'b1;
      // R4 sync gating
      cfg(mk(1, 0, 0, 1, 0, 0, 3));
      pulse_sync(); step(12);
      chk(n_bytes == 0, "R4 sync disabled gives nothing", n_bytes, 0);
      cfg(mk(0, 0, 1, 1, 0, 0, 3));
      pulse_sync(); step(12);
      chk(n_bytes == 0, "R4 global disable blocks sync", n_bytes, 0);
      cfg(mk(1, 0, 1, 1, 0, 0, 3));
      pulse_sync(); step(12);
      chk(n_sync == 1 && n_bytes == 6, "R4 one sync packet", n_bytes, 6);

      // R9 stimulus gating
      cfg(mk(1, 1, 0, 0, 0, 0, 3));
      pulse_stim(0); pulse_stim(1); step(10);
      chk(n_bytes == 6, "R9 stimulus disabled gives nothing", n_bytes, 6);
      chk(reg_rdata[23] == 1'b0, "R11 idle busy low", reg_rdata[23], 0);

      // R5 overflow, and write dropped without timestamp
      cfg(mk(1, 1, 0, 1, 0, 0, 3));
      pulse_stim(1); step(6);
      chk(n_ovf == 1 && n_ts == 0 && n_bytes == 7, "R5 overflow single byte", n_bytes, 7);
      cfg(mk(1, 0, 0, 1, 0, 0, 3));
      pulse_stim(0); step(6);
      chk(n_bytes == 7, "R6 no timestamp with ts disabled", n_bytes, 7);

      // R6/R7 group boundaries with divide-by-1
      cfg(mk(1, 1, 0, 1, 0, 0, 3));
      pulse_stim(0); step(40);
      pulse_stim(0); step(300);
      pulse_stim(0); step(16500);
      pulse_stim(0); step(20);
      chk(n_ts == 4, "R6 timestamp packets", n_ts, 4);
      chk(n_g2 >= 1, "R6 two-group packet seen", n_g2, 1);
      chk(n_g3 >= 1, "R6 three-group packet seen", n_g3, 1);

      // R7 prescaler codes, R8 tick source
      for (int sel = 0; sel < 2; sel++) begin
         for (int pr = 0; pr < 4; pr++) begin
            cfg(mk(1, 1, 0, 1, sel[0], pr, 3));
            for (int k = 0; k < 4; k++) begin
               int gap;
               gap = 50 + int'($urandom_range(0, 400));
               pulse_stim(0);
               for (int c = 0; c < gap; c++) begin
                  trace_tick = (sel != 0) ? 1'($urandom_range(0, 1)) : 1'b0;
                  step(1);
               end
            end
         end
      end
      trace_tick = 1'b0;
      step(10);
      chk(pst == 0 && !pkt_valid, "R8 stream idle after tick tests", pst, 0);

      // R10 priority with backlog and stalled port
      cfg(mk(1, 1, 1, 1, 0, 0, 3));
      step(5);
      n_log = 0;
      pkt_ready = 1'b0;
      pulse_stim(0); step(2);
      chk(pkt_valid && pkt_data == 8'hC0, "R10 ts header held", pkt_data, 8'hC0);
      pulse_stim(1); pulse_stim(0); pulse_sync(); step(3);
      chk(pkt_data == 8'hC0, "R10 stalled byte unchanged", pkt_data, 8'hC0);
      chk(reg_rdata[23] == 1'b1, "R11 busy with backlog", reg_rdata[23], 1);
      pkt_ready = 1'b1;
      step(40);
      chk(n_log == 4, "R10 packet count", n_log, 4);
      chk(log_k[0] == 3 && log_k[1] == 1 && log_k[2] == 2 && log_k[3] == 3,
          "R10 order ts,sync,ovf,ts", {log_k[0], log_k[1], log_k[2], log_k[3]}, 32'h3123);
      chk(reg_rdata[23] == 1'b0, "R11 busy clears after drain", reg_rdata[23], 0);

      // R12 disable drops backlog after current byte
      pkt_ready = 1'b0;
      pulse_sync(); step(2);
      pulse_stim(1); pulse_stim(0); step(2);
      b0 = n_bytes;
      wr(1'b0, mk(0, 1, 1, 1, 0, 0, 3));
      step(2);
      chk(pkt_valid == 1'b1, "R12 current byte still offered", pkt_valid, 1);
      pkt_ready = 1'b1;
      step(12);
      chk(n_bytes == b0 + 1, "R12 only current byte completes", n_bytes - b0, 1);
      chk(pkt_valid == 1'b0, "R12 valid low after drop", pkt_valid, 0);
      chk(reg_rdata[23] == 1'b0, "R11 busy low after drop", reg_rdata[23], 0);
      pst = 0;

      // constrained random traffic
      for (int seg = 0; seg < 6; seg++) begin
         int sel_r, pr_r;
         sel_r = int'($urandom_range(0, 1));
         pr_r  = int'($urandom_range(0, 3));
         cfg(mk(1, 1, 1, 1, sel_r[0], pr_r, 3));
         for (int c = 0; c < 2500; c++) begin
            stim_wr    = ($urandom_range(0, 7) == 0);
            fifo_full  = ($urandom_range(0, 2) == 0);
            sync_trig  = ($urandom_range(0, 59) == 0);
            pkt_ready  = ($urandom_range(0, 9) < 7);
            trace_tick = 1'($urandom_range(0, 1));
            step(1);
         end
         stim_wr = 0; fifo_full = 0; sync_trig = 0; pkt_ready = 1'b1;
         step(60);
         chk(pst == 0 && !pkt_valid, "R10 random segment drains whole packets", pst, 0);
      end
      chk(n_sync > 10 && n_ovf > 10 && n_ts > 50, "R4 R5 R6 random mix produced packets",
          n_ts, 50);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule